// File: doc/BRIEF.md
# Flash Command Sequencer with Completion Polling

This block sits on the host side of an external NOR-style flash that takes keyed command sequences. A client asks for one operation at a time: program a word, erase the whole device, erase the main area, or lock the boot region. The sequencer then drives a simple synchronous strobe bus. It issues the unlock and command writes, with every strobe held for a parameterized number of clocks. It then reads the target location repeatedly until the flash signals completion.

Completion is detected in either of two ways. The first is a bit that stops toggling between two successive reads. The second is a data bit that stops reading back inverted. For programs and erases, one more read confirms the word. A poll limit that the client sets per request ends an operation that never completes. The result is reported as a one-cycle done pulse with a status code.

Top module: `fps_seq`

## Requirements
- R1: `ready` is high exactly when no operation is in progress. A request is taken only when `req_valid` and `ready` are both high. While busy, `req_valid` has no effect on the bus activity or the result, and in idle both strobes stay high.
- R2: Operation code 0 (program) issues four writes, in this order: 0x00AA to 0x5555, 0x0055 to 0x2AAA, 0x00A0 to 0x5555, then `req_data` to `req_addr`.
- R3: Operation codes 1 (whole-device erase) and 2 (main-area erase) each issue six writes. The order is 0x00AA@0x5555, 0x0055@0x2AAA, 0x0080@0x5555, 0x00AA@0x5555, 0x0055@0x2AAA, and then 0x0010@0x5555 for code 1 or 0x0030@0x5555 for code 2.
- R4: Operation code 3 (boot lock) issues the same five-write prefix as R3 and ends with 0x0040@0x5555. It detects completion only from bit 6 and performs no confirming read.
- R5: Every write strobe (`fl_we_n`) and read strobe (`fl_oe_n`) stays low for exactly PW clocks. Each low pulse is preceded by at least PW clocks with both strobes high, and the two strobes are never low together.
- R6: The address and write data of a write change only at the end of the first high clock of its bus cycle. They then stay constant through the whole low pulse and through the first clock after the strobe rises.
- R7: After the last write, the sequencer reads `req_addr`. An operation is complete at a read whose bit 6 equals bit 6 of the previous read of the same operation. For codes 0 to 2 it is also complete when bit 7 equals bit 7 of the expected word: `req_data` for programs, all ones for erases.
- R8: If the number of reads that do not complete reaches `poll_limit`, the operation ends with status 1 (timeout). A `poll_limit` of 0 behaves as 1.
- R9: For codes 0 to 2, completion is followed by one more read of `req_addr`. The status is 0 if the word equals the expected word and 2 (verify error) otherwise. Code 3 ends with status 0 at completion.
- R10: `done` is high for exactly one clock, the clock right after the final read strobe rises. `ready` is high in that same clock, and `status` keeps its value until the next `done`.
- R11: While reset is asserted, both strobes are high, `ready` is high, and `done`, `status`, `fl_addr` and `fl_wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 program, 1 device erase, 2 main erase, 3 boot lock |
| req_addr | input | AW | Target word address (program target and poll location) |
| req_data | input | DW | Word to program |
| poll_limit | input | PCW | Maximum count of non-completing poll reads |
| ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-clock end-of-operation pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 verify error |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | DW | Flash write data |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |
| fl_rdata | input | DW | Flash read data |

## Verification
A flash model in the bench answers each read with a chosen number of busy responses, then the stored word. It records every write. Program runs with several busy lengths and with bit 7 of the data at 0 or 1 separate data-bit completion from toggle completion. Boot-lock runs show that completion from bit 6 alone needs two agreeing reads. Stored words that differ in a bit other than 6 or 7, long busy periods against small poll limits (including 0), and a request raised mid-operation separate verify errors, timeouts and ignored requests from normal completion. A behavioural reference predicts the strobe, address, data, ready and done values for every clock.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_MAIN = 2'd2,
    OP_LOCK = 2'd3
  } fps_op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_VERIFY  = 2'd2
  } fps_stat_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_HI,
    S_WR_LO,
    S_RD_HI,
    S_RD_LO
  } fps_state_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_D1     = 8'hAA;
  localparam logic [7:0]  KEY_D2     = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_SETUP = 8'h80;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_MAIN  = 8'h30;
  localparam logic [7:0]  CODE_LOCK  = 8'h40;

  // index of the final write step of each sequence
  function automatic logic [2:0] seq_last(input fps_op_e op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

endpackage

// File: rtl/fps_cmd_rom.sv
module fps_cmd_rom
  import fps_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  fps_op_e         op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [DW-1:0]   tgt_data,
  output logic [AW-1:0]   cmd_addr,
  output logic [DW-1:0]   cmd_data
);

  localparam logic [AW-1:0] KA = AW'(KEY_ADDR_A);
  localparam logic [AW-1:0] KB = AW'(KEY_ADDR_B);

  logic [7:0] final_code;

  always_comb begin
    unique case (op)
      OP_CHIP: final_code = CODE_CHIP;
      OP_MAIN: final_code = CODE_MAIN;
      OP_LOCK: final_code = CODE_LOCK;
      default: final_code = CODE_PROG;
    endcase
  end

  always_comb begin
    cmd_addr = KA;
    cmd_data = DW'(KEY_D1);
    unique case (step)
      3'd0: begin cmd_addr = KA; cmd_data = DW'(KEY_D1); end
      3'd1: begin cmd_addr = KB; cmd_data = DW'(KEY_D2); end
      3'd2: begin
        cmd_addr = KA;
        cmd_data = (op == OP_PROG) ? DW'(CODE_PROG) : DW'(CODE_SETUP);
      end
      3'd3: begin
        if (op == OP_PROG) begin
          cmd_addr = tgt_addr;
          cmd_data = tgt_data;
        end else begin
          cmd_addr = KA;
          cmd_data = DW'(KEY_D1);
        end
      end
      3'd4: begin cmd_addr = KB; cmd_data = DW'(KEY_D2); end
      default: begin cmd_addr = KA; cmd_data = DW'(final_code); end
    endcase
  end

endmodule

// File: rtl/fps_strobe_timer.sv
module fps_strobe_timer #(
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic first,
  output logic last
);

  localparam int CW = (PW > 1) ? $clog2(PW) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == CW'(PW - 1));

  always_comb begin
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: phase counter never passes the end of a phase
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PW - 1));

  // R5: a phase that ends always restarts at its first clock
  p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last) |=> first);

endmodule

// File: rtl/fps_poll_judge.sv
module fps_poll_judge #(
  parameter int DW  = 16,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           sample,
  input  logic [DW-1:0]  rdata,
  input  logic [DW-1:0]  exp_data,
  input  logic           dpoll_en,
  input  logic [PCW-1:0] limit,
  output logic           complete,
  output logic           timeout
);

  logic           prev6_q, prev6_d;
  logic           have_q, have_d;
  logic [PCW:0]   nc_q, nc_d;
  logic [PCW:0]   eff_limit;

  assign eff_limit = (limit == '0) ? (PCW+1)'(1) : {1'b0, limit};

  assign complete = (have_q && (rdata[6] == prev6_q)) ||
                    (dpoll_en && (rdata[7] == exp_data[7]));
  assign timeout  = !complete && ((nc_q + (PCW+1)'(1)) >= eff_limit);

  always_comb begin
    prev6_d = prev6_q;
    have_d  = have_q;
    nc_d    = nc_q;
    if (clear) begin
      prev6_d = 1'b0;
      have_d  = 1'b0;
      nc_d    = '0;
    end else if (sample) begin
      prev6_d = rdata[6];
      have_d  = 1'b1;
      if (!complete) nc_d = nc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev6_q <= 1'b0;
      have_q  <= 1'b0;
      nc_q    <= '0;
    end else begin
      prev6_q <= prev6_d;
      have_q  <= have_d;
      nc_q    <= nc_d;
    end
  end

  // R8: the miss count never runs past the limit the sequencer stops at
  p_nc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nc_q <= eff_limit);

endmodule

// File: rtl/fps_seq.sv
module fps_seq
  import fps_pkg::*;
#(
  parameter int AW  = 15,
  parameter int DW  = 16,
  parameter int PW  = 3,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_op,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic [PCW-1:0] poll_limit,
  output logic           ready,
  output logic           done,
  output logic [1:0]     status,
  output logic [AW-1:0]  fl_addr,
  output logic [DW-1:0]  fl_wdata,
  output logic           fl_we_n,
  output logic           fl_oe_n,
  input  logic [DW-1:0]  fl_rdata
);

  localparam int LW = $clog2(PW + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  fps_state_e     state_q, state_d;
  fps_op_e        op_q, op_d;
  logic [2:0]     step_q, step_d;
  logic [AW-1:0]  tgt_addr_q, tgt_addr_d;
  logic [DW-1:0]  tgt_data_q, tgt_data_d;
  logic [PCW-1:0] limit_q, limit_d;
  logic           vfy_q, vfy_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [DW-1:0]  wdata_q, wdata_d;
  logic           done_q, done_d;
  logic [1:0]     status_q, status_d;

  logic           tm_first, tm_last, tmr_run;
  logic [AW-1:0]  cmd_addr;
  logic [DW-1:0]  cmd_data;
  logic [DW-1:0]  exp_data;
  logic           dpoll_en;
  logic           judge_clear, judge_sample;
  logic           poll_done, poll_timeout;

  assign tmr_run  = (state_q != S_IDLE);
  assign exp_data = (op_q == OP_PROG) ? tgt_data_q : '1;
  assign dpoll_en = (op_q != OP_LOCK);

  fps_strobe_timer #(.PW(PW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_q),
    .run   (tmr_run),
    .first (tm_first),
    .last  (tm_last)
  );

  fps_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (tgt_addr_q),
    .tgt_data (tgt_data_q),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  fps_poll_judge #(.DW(DW), .PCW(PCW)) u_judge (
    .clk      (clk),
    .rst_n    (rst_q),
    .clear    (judge_clear),
    .sample   (judge_sample),
    .rdata    (fl_rdata),
    .exp_data (exp_data),
    .dpoll_en (dpoll_en),
    .limit    (limit_q),
    .complete (poll_done),
    .timeout  (poll_timeout)
  );

  always_comb begin
    state_d      = state_q;
    op_d         = op_q;
    step_d       = step_q;
    tgt_addr_d   = tgt_addr_q;
    tgt_data_d   = tgt_data_q;
    limit_d      = limit_q;
    vfy_d        = vfy_q;
    addr_d       = addr_q;
    wdata_d      = wdata_q;
    done_d       = 1'b0;
    status_d     = status_q;
    judge_clear  = 1'b0;
    judge_sample = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          state_d     = S_WR_HI;
          op_d        = fps_op_e'(req_op);
          step_d      = 3'd0;
          tgt_addr_d  = req_addr;
          tgt_data_d  = req_data;
          limit_d     = poll_limit;
          vfy_d       = 1'b0;
          judge_clear = 1'b1;
        end
      end
      S_WR_HI: begin
        if (tm_first) begin
          addr_d  = cmd_addr;
          wdata_d = cmd_data;
        end
        if (tm_last) state_d = S_WR_LO;
      end
      S_WR_LO: begin
        if (tm_last) begin
          if (step_q == seq_last(op_q)) begin
            state_d = S_RD_HI;
          end else begin
            step_d  = step_q + 3'd1;
            state_d = S_WR_HI;
          end
        end
      end
      S_RD_HI: begin
        if (tm_first) addr_d = tgt_addr_q;
        if (tm_last)  state_d = S_RD_LO;
      end
      S_RD_LO: begin
        if (tm_last) begin
          if (vfy_q) begin
            state_d  = S_IDLE;
            done_d   = 1'b1;
            status_d = (fl_rdata == exp_data) ? ST_OK : ST_VERIFY;
          end else begin
            judge_sample = 1'b1;
            if (poll_done) begin
              if (op_q != OP_LOCK) begin
                vfy_d   = 1'b1;
                state_d = S_RD_HI;
              end else begin
                state_d  = S_IDLE;
                done_d   = 1'b1;
                status_d = ST_OK;
              end
            end else if (poll_timeout) begin
              state_d  = S_IDLE;
              done_d   = 1'b1;
              status_d = ST_TIMEOUT;
            end else begin
              state_d = S_RD_HI;
            end
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q    <= S_IDLE;
      op_q       <= OP_PROG;
      step_q     <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      limit_q    <= '0;
      vfy_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      done_q     <= 1'b0;
      status_q   <= '0;
    end else begin
      state_q    <= state_d;
      op_q       <= op_d;
      step_q     <= step_d;
      tgt_addr_q <= tgt_addr_d;
      tgt_data_q <= tgt_data_d;
      limit_q    <= limit_d;
      vfy_q      <= vfy_d;
      addr_q     <= addr_d;
      wdata_q    <= wdata_d;
      done_q     <= done_d;
      status_q   <= status_d;
    end
  end

  assign ready    = (state_q == S_IDLE);
  assign done     = done_q;
  assign status   = status_q;
  assign fl_addr  = addr_q;
  assign fl_wdata = wdata_q;
  assign fl_we_n  = (state_q != S_WR_LO);
  assign fl_oe_n  = (state_q != S_RD_LO);

  // strobe width observers for the timing properties
  logic [LW-1:0] we_len_q, oe_len_q, gap_q;
  logic          strobe_low;

  assign strobe_low = !fl_we_n || !fl_oe_n;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      we_len_q <= '0;
      oe_len_q <= '0;
      gap_q    <= '0;
    end else begin
      we_len_q <= fl_we_n ? '0 : we_len_q + 1'b1;
      oe_len_q <= fl_oe_n ? '0 : oe_len_q + 1'b1;
      gap_q    <= strobe_low ? '0 :
                  ((gap_q == LW'(PW)) ? gap_q : gap_q + 1'b1);
    end
  end

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !(!fl_we_n && !fl_oe_n));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(fl_we_n) |-> (we_len_q == LW'(PW)));

  p_oe_width_r5: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(fl_oe_n) |-> (oe_len_q == LW'(PW)));

  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(strobe_low) |-> (gap_q == LW'(PW)));

  p_steady_low_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  p_hold_rise_r6: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);

  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> ready);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_q)
    ready |-> (fl_we_n && fl_oe_n));

endmodule

// File: tb/fps_seq_test.sv
module fps_seq_test;
  localparam int AW  = 15;
  localparam int DW  = 16;
  localparam int PW  = 3;
  localparam int PCW = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_valid;
  logic [1:0]     req_op;
  logic [AW-1:0]  req_addr;
  logic [DW-1:0]  req_data;
  logic [PCW-1:0] poll_limit;
  logic           ready, done;
  logic [1:0]     status;
  logic [AW-1:0]  fl_addr;
  logic [DW-1:0]  fl_wdata;
  logic           fl_we_n, fl_oe_n;
  logic [DW-1:0]  fl_rdata;

  always #10 clk = ~clk;   // 50 MHz

  fps_seq #(.AW(AW), .DW(DW), .PW(PW), .PCW(PCW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .poll_limit(poll_limit),
    .ready(ready), .done(done), .status(status), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_rdata(fl_rdata)
  );

  typedef struct packed {
    logic          we;
    logic          oe;
    logic          rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          rdy;
    logic          dn;
    logic [1:0]    st;
  } cyc_t;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } wr_t;

  cyc_t expq[$];
  wr_t  logq[$];
  wr_t  cmdq[$];

  int            checks = 0;
  int            errors = 0;
  bit            live   = 0;
  bit            log_en = 0;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd;
  logic [1:0]    last_st;
  string         st_tag;

  // flash model state
  int            busy_n;
  int            rd_k;
  logic [DW-1:0] mem_v;
  logic [DW-1:0] exp_v;
  logic [AW-1:0] wl_addr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] flash_val(input int k);
    logic [DW-1:0] v;
    v = mem_v;
    if (k <= busy_n) begin
      v[7] = ~exp_v[7];
      v[6] = k[0];
    end
    return v;
  endfunction

  always @(negedge fl_we_n) wl_addr = fl_addr;
  always @(posedge fl_we_n) if (log_en) logq.push_back('{wl_addr, fl_wdata});
  always @(negedge fl_oe_n) begin
    rd_k = rd_k + 1;
    fl_rdata = flash_val(rd_k);
  end

  // per-clock comparison against the reference trace
  always @(posedge clk) begin
    #5;
    if (live) begin
      cyc_t e;
      if (expq.size() > 0) e = expq.pop_front();
      else e = '{we:1'b1, oe:1'b1, rd:1'b0, a:pa, d:pd, rdy:1'b1, dn:1'b0, st:last_st};
      chk(fl_we_n == e.we && fl_oe_n == e.oe, "R5", "strobes",
          {fl_we_n, fl_oe_n}, {e.we, e.oe});
      chk(fl_addr == e.a, e.rd ? "R7" : "R6", "address", fl_addr, e.a);
      chk(fl_wdata == e.d, "R6", "write data", fl_wdata, e.d);
      chk(ready == e.rdy, "R1", "ready", ready, e.rdy);
      chk(done == e.dn, "R10", "done", done, e.dn);
      if (e.dn) chk(status == e.st, st_tag, "status", status, e.st);
    end
  end

  task automatic push(input logic we, input logic oe, input logic rd,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic rdy, input logic dn, input logic [1:0] st);
    expq.push_back('{we:we, oe:oe, rd:rd, a:a, d:d, rdy:rdy, dn:dn, st:st});
  endtask

  task automatic b_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int i = 0; i < PW; i++) push(1, 1, 0, (i == 0) ? pa : a, (i == 0) ? pd : d, 0, 0, 0);
    for (int i = 0; i < PW; i++) push(0, 1, 0, a, d, 0, 0, 0);
    pa = a;
    pd = d;
  endtask

  task automatic b_read(input logic [AW-1:0] a);
    for (int i = 0; i < PW; i++) push(1, 1, 1, (i == 0) ? pa : a, pd, 0, 0, 0);
    for (int i = 0; i < PW; i++) push(1, 0, 1, a, pd, 0, 0, 0);
    pa = a;
  endtask

  // called at a falling edge while idle; returns after the request clock
  task automatic start_op(input int op, input logic [AW-1:0] addr,
                          input logic [DW-1:0] data, input int limit,
                          input int busy, input logic [DW-1:0] mem,
                          input string tag);
    logic [DW-1:0] v;
    logic          prev6;
    logic [1:0]    st;
    int            nc, lim, k;
    bit            dp, comp;
    busy_n = busy;
    mem_v  = mem;
    exp_v  = (op == 0) ? data : '1;
    rd_k   = 0;
    cmdq.delete();
    logq.delete();
    cmdq.push_back('{AW'(15'h5555), DW'(16'h00AA)});
    cmdq.push_back('{AW'(15'h2AAA), DW'(16'h0055)});
    if (op == 0) begin
      cmdq.push_back('{AW'(15'h5555), DW'(16'h00A0)});
      cmdq.push_back('{addr, data});
    end else begin
      cmdq.push_back('{AW'(15'h5555), DW'(16'h0080)});
      cmdq.push_back('{AW'(15'h5555), DW'(16'h00AA)});
      cmdq.push_back('{AW'(15'h2AAA), DW'(16'h0055)});
      cmdq.push_back('{AW'(15'h5555), (op == 1) ? DW'(16'h0010) :
                                      (op == 2) ? DW'(16'h0030) : DW'(16'h0040)});
    end
    foreach (cmdq[i]) b_write(cmdq[i].a, cmdq[i].d);
    dp    = (op != 3);
    nc    = 0;
    lim   = (limit == 0) ? 1 : limit;
    k     = 1;
    prev6 = 1'b0;
    st    = 2'd0;
    forever begin
      v = flash_val(k);
      b_read(addr);
      comp = (k > 1 && v[6] == prev6) || (dp && v[7] == exp_v[7]);
      prev6 = v[6];
      if (comp) begin
        if (dp) begin
          v = flash_val(k + 1);
          b_read(addr);
          st = (v == exp_v) ? 2'd0 : 2'd2;
        end else begin
          st = 2'd0;
        end
        break;
      end
      nc++;
      if (nc >= lim) begin
        st = 2'd1;
        break;
      end
      k++;
    end
    push(1, 1, 0, pa, pd, 1, 1, st);
    last_st    = st;
    st_tag     = tag;
    req_op     = op[1:0];
    req_addr   = addr;
    req_data   = data;
    poll_limit = PCW'(limit);
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic finish_op(input string tag);
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
    chk(logq.size() == cmdq.size(), tag, "write count", logq.size(), cmdq.size());
    for (int i = 0; i < cmdq.size() && i < logq.size(); i++) begin
      chk(logq[i].a == cmdq[i].a, tag, "write address", logq[i].a, cmdq[i].a);
      chk(logq[i].d == cmdq[i].d, tag, "write data", logq[i].d, cmdq[i].d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_op     = '0;
    req_addr   = '0;
    req_data   = '0;
    poll_limit = '0;
    fl_rdata   = '0;
    rd_k       = 0;
    busy_n     = 0;
    mem_v      = '0;
    exp_v      = '0;
    pa         = '0;
    pd         = '0;
    last_st    = '0;
    st_tag     = "R9";
    repeat (3) @(negedge clk);
    // R11: reset values at the ports
    chk(fl_we_n && fl_oe_n, "R11", "strobes in reset", {fl_we_n, fl_oe_n}, 2'b11);
    chk(ready == 1'b1, "R11", "ready in reset", ready, 1);
    chk(done == 1'b0, "R11", "done in reset", done, 0);
    chk(status == 2'd0, "R11", "status in reset", status, 0);
    chk(fl_addr == '0 && fl_wdata == '0, "R11", "bus in reset", {fl_addr, fl_wdata}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live   = 1;
    log_en = 1;
    @(negedge clk);

    // R2, R9: program, data-bit completion after busy reads
    start_op(0, 15'h1234, 16'hA5C3, 20, 3, 16'hA5C3, "R9");
    finish_op("R2");
    // R7: program completing on the first read, bit 7 of data at 0
    start_op(0, 15'h0777, 16'h0F0F, 20, 0, 16'h0F0F, "R7");
    finish_op("R2");
    // R8: flash stays busy, limit reached
    start_op(0, 15'h2001, 16'h1234, 4, 50, 16'h1234, "R8");
    finish_op("R2");
    // R9: stored word wrong in bit 0, completion still seen
    start_op(0, 15'h4444, 16'h8001, 20, 2, 16'h8000, "R9");
    finish_op("R2");
    // R3: device erase
    start_op(1, 15'h0100, 16'h0000, 20, 5, 16'hFFFF, "R9");
    finish_op("R3");
    // R3: main-area erase
    start_op(2, 15'h3000, 16'h0000, 20, 1, 16'hFFFF, "R9");
    finish_op("R3");
    // R9: erase leaves a zero in bit 8
    start_op(2, 15'h3100, 16'h0000, 20, 1, 16'hFEFF, "R9");
    finish_op("R3");
    // R4: boot lock, bit-6 completion only, no confirming read
    start_op(3, 15'h0002, 16'h0000, 20, 3, 16'h0001, "R4");
    finish_op("R4");
    // R8: boot lock with limit 1 cannot complete on a single read
    start_op(3, 15'h0002, 16'h0000, 1, 0, 16'h0001, "R8");
    finish_op("R4");
    // R8: limit 0 acts as 1
    start_op(0, 15'h0055, 16'h00FF, 0, 5, 16'h00FF, "R8");
    finish_op("R2");
    // R1: a request raised mid-operation has no effect
    start_op(0, 15'h1111, 16'h2222, 20, 4, 16'h2222, "R1");
    repeat (10) @(negedge clk);
    req_op    = 2'd1;
    req_addr  = 15'h7FFF;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    finish_op("R1");
    repeat (5) @(negedge clk);

    live = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule